// File: doc/BRIEF.md
# Precise Exception Tracker for an In-Order Pipeline

This block is the exception sideband of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Every instruction slot past fetch carries a valid flag, the instruction's program counter and a three-bit exception code. Faults found in any stage are attached to the instruction and travel with it; nothing acts on them until the instruction reaches writeback. Only then does the block record the faulting PC and its cause, steer fetch to the handler vector and turn every younger in-flight instruction into a bubble. The faulting instruction itself does not retire.

External interrupts are not taken at a random point. Instead the fetch slot is replaced by a marked bubble that carries the interrupt code and the PC of the instruction it displaced. That bubble is then committed like any other fault. If a flush removes the bubble, the interrupt line is expected to remain asserted, and the bubble is simply injected again. Because commit happens in program order, an older instruction's fault always wins over a younger instruction's fault, even when the younger one was detected first.

The pipeline advances every cycle. An instruction presented at fetch in cycle t sits in decode in cycle t+1, execute t+2, memory t+3 and writeback t+4. The exception PC and cause registers update at the end of the writeback cycle.

Top module: `precise_exc_tracker`

## Requirements
- R1: After reset, no slot is valid, `wbCommit` and `redirectValid` are low, and `excPc` and `excCause` are zero.
- R2: A fault-free instruction presented at fetch in cycle t raises `wbCommit` in cycle t+4 with `wbPc` equal to its fetch PC, in program order.
- R3: Cause codes are fixed: 1 for a fetch translation fault (`itlbFault`), 2 for an illegal instruction (`decIllegal`), 3 for arithmetic overflow (`exOverflow`), 4 for a data translation fault (`memDtlbFault`) and 5 for an interrupt. After the exception is taken, `excCause` holds the code of the committed instruction.
- R4: A fault has no visible effect before its instruction reaches writeback: there is no redirect in earlier cycles, and older instructions still commit normally.
- R5: When a flagged instruction is in writeback, `redirectValid` is high for that cycle with `redirectPc` equal to the vector. `excPc` takes that instruction's PC at the end of the cycle.
- R6: The faulting instruction does not commit, and every younger instruction in flight at that moment, including the one presented at fetch in the same cycle, is discarded without commit or redirect.
- R7: If an instruction collects faults in more than one stage, the code from the earliest stage is kept.
- R8: While `irqReq` is high, the fetch slot becomes a bubble with code 5 and PC `fetchPc`. The displaced instruction never commits.
- R9: If an older instruction overflows in execute in the same cycle that a younger one is illegal in decode, only the overflow (code 3, older PC) is taken. The younger fault never redirects.
- R10: An interrupt bubble injected during a redirect cycle is flushed. An interrupt line held high afterwards injects a new bubble that is taken with its own fetch PC.
- R11: `excPc` and `excCause` hold their values in every cycle in which no exception is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchValid | input | 1 | A real instruction occupies the fetch slot this cycle |
| fetchPc | input | PC_W | PC of the fetch slot |
| itlbFault | input | 1 | Fetch translation fault for the fetch slot |
| irqReq | input | 1 | External interrupt line (level) |
| decIllegal | input | 1 | Instruction in decode is illegal |
| exOverflow | input | 1 | Instruction in execute overflowed |
| memDtlbFault | input | 1 | Instruction in memory took a data translation fault |
| wbCommit | output | 1 | Writeback instruction retires and may update state |
| wbPc | output | PC_W | PC of the writeback slot |
| redirectValid | output | 1 | Exception taken this cycle; fetch must go to the vector |
| redirectPc | output | PC_W | Handler vector address |
| excPc | output | PC_W | PC of the last committed exception |
| excCause | output | 3 | Code of the last committed exception |

## Verification
The hardest case to reach is the order inversion. A younger instruction has to flag its fault in decode in exactly the cycle that an older one overflows in execute. The bench arranges this by fetching two instructions back to back and raising both fault inputs together two cycles later. It then checks that the overflow is taken and that the illegal instruction never redirects one cycle after. A second timed case holds the interrupt line high through a redirect cycle. That makes the first bubble get flushed, and the bench confirms that only the re-injected bubble is committed.

// File: rtl/pet_pkg.sv
package pet_pkg;

  typedef enum logic [2:0] {
    EXC_NONE     = 3'd0,
    EXC_ITLB     = 3'd1,
    EXC_ILLEGAL  = 3'd2,
    EXC_OVERFLOW = 3'd3,
    EXC_DTLB     = 3'd4,
    EXC_IRQ      = 3'd5
  } excCode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic flush;    // kill every slot younger than writeback
    logic capture;  // load exception PC / cause from writeback slot
  } ctrl_t;

  // code attached by the stage that a slot occupies (0 = decode)
  function automatic excCode_t stageCode(input int stage);
    case (stage)
      0:       stageCode = EXC_ILLEGAL;
      1:       stageCode = EXC_OVERFLOW;
      default: stageCode = EXC_DTLB;
    endcase
  endfunction

endpackage

// File: rtl/pet_datapath.sv
module pet_datapath
  import pet_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_t            ctrl,
  input  logic             fetchValid,
  input  logic [PC_W-1:0]  fetchPc,
  input  logic             itlbFault,
  input  logic             irqReq,
  input  logic             decIllegal,
  input  logic             exOverflow,
  input  logic             memDtlbFault,
  output logic             wbValid,
  output logic [PC_W-1:0]  wbPc,
  output excCode_t         wbCode,
  output logic [PC_W-1:0]  excPc,
  output excCode_t         excCause
);

  localparam int NSLOT = 4;          // decode, execute, memory, writeback
  localparam int WB    = NSLOT - 1;

  logic            slotValid [NSLOT];
  logic [PC_W-1:0] slotPc    [NSLOT];
  excCode_t        slotCode  [NSLOT];
  logic            stageFault[NSLOT-1];

  logic     entryValid;
  excCode_t entryCode;

  assign stageFault[0] = decIllegal;
  assign stageFault[1] = exOverflow;
  assign stageFault[2] = memDtlbFault;

  // fetch: interrupt replaces the slot with a marked bubble
  always_comb begin
    entryValid = irqReq | fetchValid;
    if (irqReq)                       entryCode = EXC_IRQ;
    else if (fetchValid && itlbFault) entryCode = EXC_ITLB;
    else                              entryCode = EXC_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.flush) begin
      slotValid[0] <= 1'b0;
      slotPc[0]    <= '0;
      slotCode[0]  <= EXC_NONE;
    end else begin
      slotValid[0] <= entryValid;
      slotPc[0]    <= fetchPc;
      slotCode[0]  <= entryCode;
    end
  end

  for (genvar s = 1; s < NSLOT; s++) begin : g_slot
    excCode_t nextCode;
    always_comb begin
      if (slotCode[s-1] != EXC_NONE)
        nextCode = slotCode[s-1];                 // earliest stage wins
      else if (slotValid[s-1] && stageFault[s-1])
        nextCode = stageCode(s-1);
      else
        nextCode = EXC_NONE;
    end

    always_ff @(posedge clk) begin
      if (!rstN || ctrl.flush) begin
        slotValid[s] <= 1'b0;
        slotPc[s]    <= '0;
        slotCode[s]  <= EXC_NONE;
      end else begin
        slotValid[s] <= slotValid[s-1];
        slotPc[s]    <= slotPc[s-1];
        slotCode[s]  <= nextCode;
      end
    end

    // earliest fault code is carried forward unchanged
    assert_earliest_kept_R7: assert property (@(posedge clk) disable iff (!rstN)
      (slotValid[s-1] && slotCode[s-1] != EXC_NONE && !ctrl.flush)
        |=> (slotCode[s] == $past(slotCode[s-1])));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      excPc    <= '0;
      excCause <= EXC_NONE;
    end else if (ctrl.capture) begin
      excPc    <= slotPc[WB];
      excCause <= slotCode[WB];
    end
  end

  assign wbValid = slotValid[WB];
  assign wbPc    = slotPc[WB];
  assign wbCode  = slotCode[WB];

  assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.flush |=> !(slotValid[0] || slotValid[1] || slotValid[2] || slotValid[3]));

  assert_capture_wb_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.capture |=> (excPc == $past(slotPc[WB]) && excCause == $past(slotCode[WB])));

  assert_hold_regs_R11: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.capture |=> ($stable(excPc) && $stable(excCause)));

  assert_irq_bubble_R8: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && !ctrl.flush) |=> (slotValid[0] && slotCode[0] == EXC_IRQ));

endmodule

// File: rtl/pet_control.sv
module pet_control
  import pet_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     wbValid,
  input  excCode_t wbCode,
  output ctrl_t    ctrl,
  output logic     redirectValid,
  output logic     wbCommit
);

  logic take;

  assign take          = wbValid && (wbCode != EXC_NONE);
  assign ctrl.flush    = take;
  assign ctrl.capture  = take;
  assign redirectValid = take;
  assign wbCommit      = wbValid && !take;

  // a taken exception leaves nothing behind that could redirect next cycle
  assert_single_redirect_R9: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |=> !redirectValid);

  // after a redirect the pipe is empty, so nothing retires next cycle
  assert_no_commit_after_R6: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |=> !wbCommit);

endmodule

// File: rtl/precise_exc_tracker.sv
module precise_exc_tracker
  import pet_pkg::*;
#(
  parameter int              PC_W   = 32,
  parameter logic [PC_W-1:0] VECTOR = 32'h0000_0080
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            fetchValid,
  input  logic [PC_W-1:0] fetchPc,
  input  logic            itlbFault,
  input  logic            irqReq,
  input  logic            decIllegal,
  input  logic            exOverflow,
  input  logic            memDtlbFault,
  output logic            wbCommit,
  output logic [PC_W-1:0] wbPc,
  output logic            redirectValid,
  output logic [PC_W-1:0] redirectPc,
  output logic [PC_W-1:0] excPc,
  output logic [2:0]      excCause
);

  ctrl_t    ctrl;
  logic     wbValid;
  excCode_t wbCode;
  excCode_t causeQ;

  pet_datapath #(.PC_W(PC_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .fetchValid   (fetchValid),
    .fetchPc      (fetchPc),
    .itlbFault    (itlbFault),
    .irqReq       (irqReq),
    .decIllegal   (decIllegal),
    .exOverflow   (exOverflow),
    .memDtlbFault (memDtlbFault),
    .wbValid      (wbValid),
    .wbPc         (wbPc),
    .wbCode       (wbCode),
    .excPc        (excPc),
    .excCause     (causeQ)
  );

  pet_control u_ctl (
    .clk           (clk),
    .rstN          (rstN),
    .wbValid       (wbValid),
    .wbCode        (wbCode),
    .ctrl          (ctrl),
    .redirectValid (redirectValid),
    .wbCommit      (wbCommit)
  );

  assign redirectPc = VECTOR;
  assign excCause   = causeQ;

  assert_cause_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |=> (excCause >= 3'd1 && excCause <= 3'd5));

endmodule

// File: tb/precise_exc_tracker_tb.sv
`timescale 1ns/1ps
module precise_exc_tracker_tb;

  localparam int          PC_W = 32;
  localparam logic [31:0] VEC  = 32'h0000_0080;

  logic            clk = 1'b0;
  logic            rstN;
  logic            fetchValid, itlbFault, irqReq, decIllegal, exOverflow, memDtlbFault;
  logic [PC_W-1:0] fetchPc;
  logic            wbCommit, redirectValid;
  logic [PC_W-1:0] wbPc, redirectPc, excPc;
  logic [2:0]      excCause;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  precise_exc_tracker #(.PC_W(PC_W), .VECTOR(VEC)) u_dut (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchPc(fetchPc),
    .itlbFault(itlbFault), .irqReq(irqReq), .decIllegal(decIllegal),
    .exOverflow(exOverflow), .memDtlbFault(memDtlbFault),
    .wbCommit(wbCommit), .wbPc(wbPc), .redirectValid(redirectValid),
    .redirectPc(redirectPc), .excPc(excPc), .excCause(excCause)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // advance to the next cycle and idle all inputs
  task automatic tick();
    @(negedge clk);
    fetchValid = 0; itlbFault = 0; irqReq = 0;
    decIllegal = 0; exOverflow = 0; memDtlbFault = 0; fetchPc = '0;
  endtask

  task automatic fetch(input logic [31:0] pc, input bit itlb);
    fetchValid = 1; fetchPc = pc; itlbFault = itlb;
  endtask

  task automatic drain();
    for (int i = 0; i < 6; i++) tick();
  endtask

  task automatic test_reset();
    check(!wbCommit && !redirectValid, "R1", "outputs idle", {wbCommit, redirectValid}, 0);
    check(excPc == 0 && excCause == 0, "R1", "exc regs clear", {excPc[28:0], excCause}, 0);
  endtask

  task automatic test_clean_flow();
    logic [31:0] savedPc;
    logic [2:0]  savedCause;
    savedPc = excPc; savedCause = excCause;
    tick(); fetch(32'h100, 0);
    tick(); fetch(32'h104, 0);
    tick(); tick(); tick();
    check(wbCommit && wbPc == 32'h100 && !redirectValid, "R2", "first retire", wbPc, 32'h100);
    tick();
    check(wbCommit && wbPc == 32'h104, "R2", "second retire in order", wbPc, 32'h104);
    tick();
    check(!wbCommit, "R2", "pipe empty", wbCommit, 0);
    check(excPc == savedPc && excCause == savedCause, "R11", "regs held", excPc, savedPc);
  endtask

  // stage: 1 fetch, 2 decode, 3 execute, 4 memory
  task automatic test_stage_fault(input int stage, input logic [31:0] p);
    bit stray;
    tick(); fetch(p - 4, 0);
    tick(); fetch(p, stage == 1);
    tick(); fetch(p + 4, 0);  if (stage == 2) decIllegal = 1;
    tick(); fetch(p + 8, 0);  if (stage == 3) exOverflow = 1;
    check(!redirectValid, "R4", "no early redirect", redirectValid, 0);
    tick(); fetch(p + 12, 0); if (stage == 4) memDtlbFault = 1;
    check(wbCommit && wbPc == p - 4 && !redirectValid, "R4", "older still commits", wbPc, p - 4);
    tick(); fetch(p + 16, 0);
    check(redirectValid && redirectPc == VEC, "R5", "redirect to vector", redirectPc, VEC);
    check(!wbCommit, "R6", "faulting instr not committed", wbCommit, 0);
    tick();
    check(excPc == p, "R5", "exc pc captured", excPc, p);
    check(excCause == 3'(stage), "R3", "cause code per stage", excCause, stage);
    stray = 0;
    for (int i = 0; i < 5; i++) begin
      if (wbCommit || redirectValid) stray = 1;
      tick();
    end
    check(!stray, "R6", "younger instrs flushed", stray, 0);
  endtask

  task automatic test_multi_fault();
    tick(); fetch(32'h300, 1);
    tick(); decIllegal = 1;
    tick(); exOverflow = 1;
    tick(); memDtlbFault = 1;
    tick();
    check(redirectValid, "R7", "redirect", redirectValid, 1);
    tick();
    check(excCause == 3'd1, "R7", "earliest code kept", excCause, 1);
    drain();
  endtask

  task automatic test_order();
    tick(); fetch(32'h400, 0);          // older A
    tick(); fetch(32'h404, 0);          // younger B
    tick(); exOverflow = 1; decIllegal = 1;  // A in execute, B in decode
    tick(); tick();
    check(redirectValid && !wbCommit, "R9", "older overflow taken", redirectValid, 1);
    tick();
    check(excPc == 32'h400 && excCause == 3'd3, "R9", "older pc and overflow code",
          {excPc[28:0], excCause}, {29'h400, 3'd3});
    check(!redirectValid && !wbCommit, "R9", "younger illegal discarded", redirectValid, 0);
    tick();
    check(!redirectValid && excCause == 3'd3, "R9", "no late redirect", excCause, 3);
    drain();
  endtask

  task automatic test_irq();
    tick(); fetch(32'h600, 0); irqReq = 1;
    tick(); tick(); tick();
    check(!wbCommit, "R8", "no early commit", wbCommit, 0);
    tick();
    check(redirectValid && !wbCommit, "R8", "irq bubble taken, displaced not committed",
          {wbCommit, redirectValid}, 1);
    tick();
    check(excPc == 32'h600 && excCause == 3'd5, "R8", "irq pc and code",
          {excPc[28:0], excCause}, {29'h600, 3'd5});
    drain();
  endtask

  task automatic test_irq_flushed();
    tick(); fetch(32'h700, 1);                 // c0
    tick(); tick(); tick();                    // c1..c3
    tick(); irqReq = 1; fetchPc = 32'h500;     // c4: redirect cycle
    check(redirectValid, "R10", "itlb redirect", redirectValid, 1);
    tick(); irqReq = 1; fetchPc = 32'h504;     // c5: line still high
    check(excPc == 32'h700 && excCause == 3'd1, "R10", "itlb captured", excPc, 32'h700);
    tick(); tick();                            // c6, c7
    tick();                                    // c8
    check(!redirectValid, "R10", "flushed bubble gone", redirectValid, 0);
    tick();                                    // c9
    check(redirectValid, "R10", "reinjected bubble taken", redirectValid, 1);
    tick();                                    // c10
    check(excPc == 32'h504 && excCause == 3'd5, "R10", "reinjected pc/code",
          {excPc[28:0], excCause}, {29'h504, 3'd5});
    drain();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 0;
    fetchValid = 0; itlbFault = 0; irqReq = 0; fetchPc = '0;
    decIllegal = 0; exOverflow = 0; memDtlbFault = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    test_reset();
    test_clean_flow();
    test_stage_fault(1, 32'h1000);
    test_stage_fault(2, 32'h2000);
    test_stage_fault(3, 32'h3000);
    test_stage_fault(4, 32'h4000);
    test_multi_fault();
    test_order();
    test_irq();
    test_irq_flushed();
    test_clean_flow();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule